// File: doc/BRIEF.md
# One-Shot Event Timer with Interrupt

This block is a countdown timer that raises one event. Software reaches it through a small register port and uses it to schedule the next timer event. Software first writes a divisor. A control write with the load operation then copies that divisor into the counter. A second control write with the run operation starts the countdown. A frequency field picks the rate of the decrement. The fastest setting moves the counter once per clock, which is 10 ns on a 100 MHz system. Software can read the remaining count at any time, so the elapsed time is the divisor minus the count, multiplied by the tick period.

When the counter reaches zero it sets a pending flag and then stays at zero until the next load. A mask register gates the pending flag onto a masked-status register and onto the interrupt line. Writing a one to the acknowledge register clears the flag. Beside the timer, a free-running 32-bit time counter advances once per clock and can be read at any moment as a timestamp.

Register addresses on the word-indexed port:
- 0: divisor.
- 1: control.
- 2: current count, read only.
- 3: mask.
- 4: acknowledge, which reads as zero.
- 5: masked status.
- 6: time counter.

Reads of any other address return zero.

Top module: `event_timer`

## Requirements
- R1: After reset every register reads zero, the operation is hold, and `irq` is low. The divisor written at address 0 reads back unchanged. Control at address 1 reads back with the operation in bits [1:0] and the frequency in bits [3:2].
- R2: A control write whose operation is load (code 1) copies the divisor into the count in the next cycle. The count then holds that value and does not decrement.
- R3: With the operation set to run (code 2) and frequency code 0, the count at address 2 drops by one every clock. After n clocks it reads divisor minus n.
- R4: While the operation is hold (code 0), the count keeps its value and no event is raised. Reserved operation code 3 behaves the same way.
- R5: The decrement that takes the count from 1 to 0 sets the pending flag. The count then stays at 0 until the next load (one-shot).
- R6: Frequency code 1 decrements once every PRE_A clocks, and code 2 once every PRE_B clocks. In both cases the prescaler starts from zero at each control write. Code 3 never decrements.
- R7: Bit 0 of the masked-status register equals pending AND mask bit 0, and `irq` is the OR of the masked-status bits.
- R8: Writing a word with bit 0 set to the acknowledge register clears the pending flag. A write with bit 0 clear leaves the flag unchanged.
- R9: If an acknowledge write falls in the same cycle as the decrement to zero, the pending flag stays set.
- R10: The time counter at address 6 is zero in reset and increases by one every clock. Two reads n clocks apart differ by n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| we | input | 1 | Register write strobe |
| addr | input | ADDR_W | Word address for the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request, OR of the masked status |

## Verification
A table of vectors arms the timer with different divisors and frequency codes, then reads the count after a set wait. This separates the per-clock rate, both prescaled rates, and the frozen code 3. A short divisor with a long wait shows that the count stops at zero instead of wrapping. Directed tests then do four things:
- They stop a running count with hold and confirm that the count freezes.
- They toggle the mask to show pending separately from the masked status.
- They acknowledge with bit 0 clear and then with bit 0 set.
- They place an acknowledge on the exact cycle of the zero crossing, where the event must win.

// File: rtl/event_timer.sv
module event_timer #(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int TIME_W = 32,
  parameter int PRE_A  = 10,
  parameter int PRE_B  = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);

  localparam int PRE_MAX = (PRE_A > PRE_B) ? PRE_A : PRE_B;
  localparam int PRE_W   = $clog2(PRE_MAX + 1);

  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(6);

  typedef enum logic [1:0] {OP_HOLD = 2'd0, OP_LOAD = 2'd1, OP_RUN = 2'd2, OP_RSVD = 2'd3} op_t;

  logic [CNT_W-1:0]  div_q, cnt_q;
  logic [1:0]        op_q, freq_q;
  logic [PRE_W-1:0]  pre_q;
  logic              mask_q, pend_q;
  logic [TIME_W-1:0] time_q;

  logic ctrl_wr, ack_wr, tick, dec, fire, stat;

  assign ctrl_wr = we && (addr == A_CTRL);
  assign ack_wr  = we && (addr == A_ACK) && wdata[0];

  always_comb begin
    case (freq_q)
      2'd0:    tick = 1'b1;
      2'd1:    tick = (pre_q == PRE_W'(PRE_A - 1));
      2'd2:    tick = (pre_q == PRE_W'(PRE_B - 1));
      default: tick = 1'b0;
    endcase
  end

  assign dec  = (op_q == OP_RUN) && tick && (cnt_q != '0) && !ctrl_wr;
  assign fire = dec && (cnt_q == CNT_W'(1));
  assign stat = pend_q & mask_q;
  assign irq  = stat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      op_q   <= OP_HOLD;
      freq_q <= '0;
      mask_q <= 1'b0;
    end else if (we) begin
      case (addr)
        A_DIV:  div_q  <= wdata[CNT_W-1:0];
        A_CTRL: begin
          op_q   <= wdata[1:0];
          freq_q <= wdata[3:2];
        end
        A_MASK: mask_q <= wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pre_q <= '0;
    else if (ctrl_wr)               pre_q <= '0;
    else if (op_q == OP_RUN)        pre_q <= tick ? '0 : pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cnt_q <= '0;
    else if (ctrl_wr && wdata[1:0] == OP_LOAD)   cnt_q <= div_q;
    else if (dec)                                cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= 1'b0;
    else if (fire)   pend_q <= 1'b1;
    else if (ack_wr) pend_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) time_q <= '0;
    else        time_q <= time_q + 1'b1;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_DIV:  rdata = DATA_W'(div_q);
      A_CTRL: rdata = DATA_W'({freq_q, op_q});
      A_CNT:  rdata = DATA_W'(cnt_q);
      A_MASK: rdata = DATA_W'(mask_q);
      A_STAT: rdata = DATA_W'(stat);
      A_TIME: rdata = DATA_W'(time_q);
      default: rdata = '0;
    endcase
  end

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[1:0] == OP_LOAD) |=> (cnt_q == $past(div_q))); // R2
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_RUN && !ctrl_wr) |=> ($stable(cnt_q) && !$rose(pend_q))); // R4
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !ctrl_wr) |=> (cnt_q == '0)); // R5
  AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && cnt_q == CNT_W'(1)) |=> pend_q); // R9
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !(dec && cnt_q == CNT_W'(1))) |=> !pend_q); // R8
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (time_q == $past(time_q) + 1'b1)); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend_q && mask_q)); // R7

endmodule

// File: tb/sim_event_timer.sv
module sim_event_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  event_timer #(.PRE_A(4), .PRE_B(8)) u0 (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // {divisor[15:0], freq[7:0], wait[7:0], expected count[15:0]}
  localparam logic [47:0] VEC [6] = '{
    {16'd50,  8'd0, 8'd7,  16'd43},
    {16'd50,  8'd1, 8'd9,  16'd48},
    {16'd50,  8'd2, 8'd17, 16'd48},
    {16'd50,  8'd3, 8'd20, 16'd50},
    {16'd5,   8'd0, 8'd12, 16'd0},
    {16'd200, 8'd1, 8'd40, 16'd190}
  };

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic arm(input logic [31:0] div, input logic [1:0] freq);
    wr(3'd0, div);
    wr(3'd1, {28'd0, freq, 2'd1});
    wr(3'd1, {28'd0, freq, 2'd2});
  endtask

  initial begin
    logic [31:0] v, t1, t2;
    #1;
    rd(3'd6, v); chk("R10 time in reset", v, 0);
    rd(3'd2, v); chk("R1 count in reset", v, 0);
    chk("R1 irq in reset", {31'd0, irq}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd1, v); chk("R1 control after reset", v, 0);
    rd(3'd5, v); chk("R1 status after reset", v, 0);

    wr(3'd0, 32'h0000_1234);
    rd(3'd0, v); chk("R1 divisor readback", v, 32'h1234);
    wr(3'd1, 32'h0000_000D);
    rd(3'd1, v); chk("R1 control readback", v, 32'hD);
    wr(3'd1, 32'h0);

    for (int i = 0; i < 6; i++) begin
      wr(3'd0, {16'd0, VEC[i][47:32]});
      wr(3'd1, {28'd0, VEC[i][25:24], 2'd1});
      repeat (3) @(negedge clk);
      rd(3'd2, v); chk("R2 load without countdown", v, {16'd0, VEC[i][47:32]});
      wr(3'd1, {28'd0, VEC[i][25:24], 2'd2});
      repeat (VEC[i][23:16]) @(negedge clk);
      rd(3'd2, v); chk("R3 R5 R6 vector count", v, {16'd0, VEC[i][15:0]});
    end

    // pending set by the divisor-5 vector; mask still zero
    rd(3'd5, v); chk("R7 masked while mask off", v, 0);
    chk("R7 irq low while mask off", {31'd0, irq}, 0);
    wr(3'd3, 32'd1);
    rd(3'd5, v); chk("R5 R7 status after zero", v, 1);
    chk("R7 irq high", {31'd0, irq}, 1);
    wr(3'd4, 32'd2);
    rd(3'd5, v); chk("R8 ack with bit0 clear ignored", v, 1);
    wr(3'd4, 32'd1);
    rd(3'd5, v); chk("R8 ack clears", v, 0);
    chk("R8 irq low after ack", {31'd0, irq}, 0);

    // hold freezes a running count
    arm(32'd20, 2'd0);
    repeat (5) @(negedge clk);
    wr(3'd1, 32'd0);
    rd(3'd2, v); chk("R4 count at hold", v, 14);
    repeat (30) @(negedge clk);
    rd(3'd2, v); chk("R4 count frozen", v, 14);
    rd(3'd5, v); chk("R4 no event in hold", v, 0);
    wr(3'd1, 32'd3);
    repeat (10) @(negedge clk);
    rd(3'd2, v); chk("R4 reserved op frozen", v, 14);

    // ack on the same edge as the zero crossing
    arm(32'd3, 2'd0);
    @(negedge clk);
    wr(3'd4, 32'd1);
    rd(3'd2, v); chk("R9 count reached zero", v, 0);
    rd(3'd5, v); chk("R9 event wins over ack", v, 1);
    wr(3'd4, 32'd1);
    rd(3'd5, v); chk("R9 later ack clears", v, 0);

    rd(3'd6, t1);
    repeat (10) @(negedge clk);
    rd(3'd6, t2);
    chk("R10 time delta", t2 - t1, 10);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule